// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block gathers the bytes of one instruction for a processor whose instructions are 1 to 7 bytes long. An instruction may begin at any byte address. The decoder only learns the length after the bytes arrive, so the block never tries to guess it. It always reads the three consecutive 32-bit words that begin with the word holding the program counter, which covers a 7-byte instruction at the worst alignment.

After the third word arrives, the block shifts the 12 gathered bytes down by the program counter's byte offset. It then presents 7 bytes with the opcode in byte 0, and raises a valid flag for one cycle.

A fetch starts when the start strobe is seen while the block is idle. The memory side is a Wishbone-style read master. It makes one word read at a time and holds each read until that read is acknowledged.

Top module: `ifetch_aligner`

## Requirements
- R1: While reset is low, and in the cycle after it, `wb_cyc_o`, `wb_stb_o` and `valid_o` are low.
- R2: A start strobe sampled while idle makes the next cycle drive `wb_cyc_o` and `wb_stb_o` high, with `wb_adr_o` equal to the program counter with its two low bits cleared.
- R3: Exactly three word reads are made per fetch. Each read after the first uses the previous byte address plus 4, wrapping modulo 2^32.
- R4: A read keeps `wb_cyc_o`, `wb_stb_o` and `wb_adr_o` unchanged until a cycle in which `wb_ack_i` is high.
- R5: In the cycle after the third acknowledge, `wb_cyc_o` and `wb_stb_o` are low and `valid_o` is high. In the cycle after that, `valid_o` is low again.
- R6: When `valid_o` is high, byte k of `insn_o` (bits 8k+7:8k, k = 0..6) equals the memory byte at address PC+k modulo 2^32. Memory words are little-endian: bits 7:0 of a word hold its lowest-addressed byte.
- R7: A start strobe that arrives during a fetch is ignored, including in the cycle of the third acknowledge. The fetch finishes with the original program counter, and no new fetch follows.
- R8: An acknowledge that arrives while no read is outstanding is ignored. It raises neither `valid_o` nor a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Byte program counter of the instruction to fetch |
| start_i | input | 1 | Begins a fetch when sampled while idle |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Read strobe |
| wb_adr_o | output | 32 | Word-aligned byte address of the current read |
| wb_ack_i | input | 1 | Read acknowledge |
| wb_dat_i | input | 32 | Read data |
| insn_o | output | 56 | Aligned instruction bytes, opcode in bits 7:0 |
| valid_o | output | 1 | One-cycle flag that `insn_o` holds a new instruction |

## Verification
Two functions of the block can fall in the same cycle:
- The last word capture, which ends the fetch and raises the valid flag.
- Start-strobe acceptance.

The bench provokes the overlap by holding a fresh start strobe, with a different program counter, across the second and third acknowledges while the memory model acknowledges every read at once. The result is judged at the ports. The delivered bytes must belong to the original program counter, and the cycle after the valid pulse must show no new bus cycle.

A separate phase drives acknowledges while idle and expects neither a valid flag nor a bus cycle. Program counters near the top of the address space check that the read addresses wrap.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  localparam int IFA_ADDR_W      = 32;
  localparam int IFA_WORD_W      = 32;
  localparam int IFA_FETCH_WORDS = 3;
  localparam int IFA_INSN_BYTES  = 7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } ifa_state_e;
endpackage

// File: rtl/ifa_ctrl.sv
module ifa_ctrl
  import ifa_pkg::*;
#(
  parameter int ADDR_W = IFA_ADDR_W,
  parameter int OFF_W  = 2,
  parameter int NWORDS = IFA_FETCH_WORDS,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              ack_i,
  output logic              cyc_o,
  output logic              stb_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [ADDR_W-1:0] pc_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              take_start,
  output logic              beat_done,
  output logic              last_beat,
  output logic              valid_o
);
  localparam int WADR_W = ADDR_W - OFF_W;

  ifa_state_e state_q;

  // word address of read k of the fetch for a given program counter
  function automatic logic [WADR_W-1:0] word_of(input logic [ADDR_W-1:0] pc,
                                                input logic [IDX_W-1:0]  k);
    return pc[ADDR_W-1:OFF_W] + WADR_W'(k);
  endfunction

  assign cyc_o      = (state_q == ST_READ);
  assign stb_o      = (state_q == ST_READ);
  assign adr_o      = {word_of(pc_q, idx_q), {OFF_W{1'b0}}};
  assign take_start = (state_q == ST_IDLE) && start_i;
  assign beat_done  = cyc_o && stb_o && ack_i;
  assign last_beat  = beat_done && (idx_q == IDX_W'(NWORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pc_q    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            pc_q    <= pc_i;
            idx_q   <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (last_beat) begin
            state_q <= ST_IDLE;
            valid_o <= 1'b1;
          end else if (beat_done) begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ifa_capture.sv
module ifa_capture #(
  parameter int NWORDS = 3,
  parameter int WORD_W = 32,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int LINE_W = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_done,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] dat_i,
  output logic [LINE_W-1:0] line_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_o[g*WORD_W +: WORD_W] <= '0;
      end else if (beat_done && (idx == IDX_W'(g))) begin
        line_o[g*WORD_W +: WORD_W] <= dat_i;
      end
    end
  end
endmodule

// File: rtl/ifa_align.sv
module ifa_align #(
  parameter int LINE_W = 96,
  parameter int OFF_W  = 2,
  parameter int INSN_W = 56
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [INSN_W-1:0] insn_o
);
  // drop the bytes that precede the program counter
  function automatic logic [LINE_W-1:0] drop_bytes(input logic [LINE_W-1:0] ln,
                                                   input logic [OFF_W-1:0]  n);
    return ln >> ({3'b000, n} * 8);
  endfunction

  logic [LINE_W-1:0] shifted;

  assign shifted = drop_bytes(line_i, off_i);
  assign insn_o  = shifted[INSN_W-1:0];
endmodule

// File: rtl/ifetch_aligner.sv
module ifetch_aligner
  import ifa_pkg::*;
#(
  parameter int ADDR_W     = IFA_ADDR_W,
  parameter int WORD_W     = IFA_WORD_W,
  parameter int NWORDS     = IFA_FETCH_WORDS,
  parameter int INSN_BYTES = IFA_INSN_BYTES,
  localparam int OFF_W  = $clog2(WORD_W / 8),
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int LINE_W = NWORDS * WORD_W,
  localparam int INSN_W = INSN_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              start_i,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic              wb_ack_i,
  input  logic [WORD_W-1:0] wb_dat_i,
  output logic [INSN_W-1:0] insn_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [IDX_W-1:0]  idx_q;
  logic              take_start;
  logic              beat_done;
  logic              last_beat;
  logic [LINE_W-1:0] line;

  ifa_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NWORDS(NWORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pc_i      (pc_i),
    .ack_i     (wb_ack_i),
    .cyc_o     (wb_cyc_o),
    .stb_o     (wb_stb_o),
    .adr_o     (wb_adr_o),
    .pc_q      (pc_q),
    .idx_q     (idx_q),
    .take_start(take_start),
    .beat_done (beat_done),
    .last_beat (last_beat),
    .valid_o   (valid_o)
  );

  ifa_capture #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_done(beat_done),
    .idx      (idx_q),
    .dat_i    (wb_dat_i),
    .line_o   (line)
  );

  ifa_align #(.LINE_W(LINE_W), .OFF_W(OFF_W), .INSN_W(INSN_W)) u_align (
    .line_i(line),
    .off_i (pc_q[OFF_W-1:0]),
    .insn_o(insn_o)
  );
endmodule

// File: rtl/ifa_chk.sv
module ifa_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic              wb_ack_i,
  input logic              valid_o,
  input logic              take_start,
  input logic              beat_done,
  input logic              last_beat,
  input logic [ADDR_W-1:0] pc_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!wb_cyc_o && !wb_stb_o && !valid_o));

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> (wb_cyc_o && wb_stb_o &&
                    wb_adr_o == ($past(pc_i) & ~ADDR_W'(3))));

  // R3
  next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !last_beat) |=> (wb_adr_o == $past(wb_adr_o) + ADDR_W'(4)));

  // R4
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_stb_o && !wb_ack_i) |=>
      (wb_cyc_o && wb_stb_o && $stable(wb_adr_o)));

  // R5
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (valid_o && !wb_cyc_o && !wb_stb_o));

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && start_i) |=> $stable(pc_q));

  // R8
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_cyc_o |=> !valid_o);
endmodule

bind ifetch_aligner ifa_chk #(.ADDR_W(ADDR_W)) u_ifa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .pc_i      (pc_i),
  .wb_cyc_o  (wb_cyc_o),
  .wb_stb_o  (wb_stb_o),
  .wb_adr_o  (wb_adr_o),
  .wb_ack_i  (wb_ack_i),
  .valid_o   (valid_o),
  .take_start(take_start),
  .beat_done (beat_done),
  .last_beat (last_beat),
  .pc_q      (pc_q)
);

// File: tb/ifetch_aligner_bench.sv
module ifetch_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic        start_i = 1'b0;
  logic        wb_cyc_o, wb_stb_o;
  logic [31:0] wb_adr_o;
  logic        wb_ack_i = 1'b0;
  logic [31:0] wb_dat_i = '0;
  logic [55:0] insn_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model state, driven from the slave process
  bit          force_ack = 0;
  bit          stray = 0;
  int          nbeats = 0;
  logic [31:0] beat_adr [8];
  bit          prev_wait = 0;
  logic [31:0] prev_adr = '0;
  int          hold_err = 0;

  always #2 clk = ~clk;   // 250 MHz

  ifetch_aligner u_ifetch_aligner (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .start_i(start_i),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_adr_o(wb_adr_o),
    .wb_ack_i(wb_ack_i), .wb_dat_i(wb_dat_i), .insn_o(insn_o), .valid_o(valid_o)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E37_79B1;
    return h[31:24] ^ a[7:0];
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  function automatic logic [55:0] expect_insn(input logic [31:0] pc);
    logic [55:0] r;
    for (int k = 0; k < 7; k++) r[k*8 +: 8] = mem_byte(pc + 32'(k));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory slave: decides acknowledges at the falling edge
  always @(negedge clk) begin
    if (wb_cyc_o && wb_stb_o) begin
      if (prev_wait && wb_adr_o != prev_adr) hold_err++;
      wb_ack_i = force_ack || ($urandom % 3 != 0);
      wb_dat_i = mem_word(wb_adr_o);
      if (wb_ack_i && nbeats < 8) beat_adr[nbeats] = wb_adr_o;
      if (wb_ack_i) nbeats++;
      prev_wait = !wb_ack_i;
      prev_adr  = wb_adr_o;
    end else begin
      wb_ack_i  = stray;
      wb_dat_i  = $urandom;
      prev_wait = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_fetch(input logic [31:0] pc, input bit busy_start);
    int  t;
    bit  seen;
    @(negedge clk); #1;
    nbeats = 0; hold_err = 0;
    pc_i = pc; start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    pc_i = $urandom;
    // R2: first read is the word holding the program counter
    check(wb_cyc_o && wb_stb_o && wb_adr_o == (pc & ~32'd3), "R2", "first read",
          {31'd0, wb_cyc_o, wb_adr_o}, {32'd1, pc & ~32'd3});
    seen = 0;
    for (t = 0; t < 200 && !seen; t++) begin
      if (busy_start && nbeats == 2 && !start_i && wb_cyc_o) begin
        pc_i = pc ^ 32'h0000_0105; start_i = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        start_i = 1'b0;
      end else begin
        @(negedge clk); #1;
      end
      if (valid_o) seen = 1;
    end
    check(seen, "R5", "valid raised", {63'd0, seen}, 64'd1);
    if (seen) begin
      check(nbeats == 3, "R3", "read count", 64'(nbeats), 64'd3);
      for (int b = 1; b < 3; b++)
        check(beat_adr[b] == (pc & ~32'd3) + 32'(4 * b), "R3", "read address",
              {32'd0, beat_adr[b]}, {32'd0, (pc & ~32'd3) + 32'(4 * b)});
      check(hold_err == 0, "R4", "read held until ack", 64'(hold_err), 64'd0);
      check(!wb_cyc_o && !wb_stb_o, "R5", "bus released",
            {62'd0, wb_cyc_o, wb_stb_o}, 64'd0);
      check(insn_o == expect_insn(pc), busy_start ? "R7" : "R6", "aligned bytes",
            {8'd0, insn_o}, {8'd0, expect_insn(pc)});
      @(negedge clk); #1;
      check(!valid_o, "R5", "valid one cycle", {63'd0, valid_o}, 64'd0);
      if (busy_start)
        check(!wb_cyc_o, "R7", "no fetch after busy start", {63'd0, wb_cyc_o}, 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(!wb_cyc_o && !wb_stb_o && !valid_o, "R1", "reset outputs",
          {61'd0, wb_cyc_o, wb_stb_o, valid_o}, 64'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    check(!wb_cyc_o && !wb_stb_o && !valid_o, "R1", "after reset",
          {61'd0, wb_cyc_o, wb_stb_o, valid_o}, 64'd0);

    // R6: every byte offset
    for (int o = 0; o < 4; o++) do_fetch(32'h0000_1230 + 32'(o), 0);
    // R3: wrap at the top of the address space
    do_fetch(32'hFFFF_FFFD, 0);
    do_fetch(32'hFFFF_FFF8, 0);
    // R7: start held across the last acknowledges
    force_ack = 1;
    do_fetch(32'h0000_4002, 1);
    do_fetch(32'h8000_0007, 1);
    force_ack = 0;
    do_fetch(32'h0000_7001, 1);

    // R8: acknowledges while idle
    stray = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      check(!valid_o && !wb_cyc_o, "R8", "stray ack ignored",
            {62'd0, valid_o, wb_cyc_o}, 64'd0);
    end
    stray = 0;

    for (int i = 0; i < 40; i++) begin
      force_ack = ($urandom % 4 == 0);
      do_fetch($urandom, ($urandom % 5 == 0));
    end
    force_ack = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule